// File: doc/BRIEF.md
# Set-Associative Page Translation Buffer

This block keeps recently used virtual-to-physical page translations for a paged memory unit with 4 KB pages. A lookup presents a 32-bit virtual address, a write flag and a user/supervisor flag. One cycle later the block answers with a hit flag and the translated physical address. The low 12 offset bits pass through unchanged. It also raises a permission-fault flag and a flag that says the page-table entry must have its dirty bit set before the write goes ahead.

Storage is 32 entries arranged as 8 sets of 4 ways. The set is picked by the low three bits of the virtual page number. A page walker outside the block installs translations through a fill port. Each entry holds a present bit, a writable bit, a user bit and a dirty bit beside the frame number. Having an entry at all means the page has been accessed. A single flush input clears the whole buffer. It is pulsed whenever the page-directory base register is written, including on a task switch. No other invalidation exists.

Top module: `tlb_top`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, and `respValid` and `respHit` are low.
- R2: A lookup presented with `lookupValid` high at a clock edge is answered after that edge: `respValid` is high for exactly that cycle. With no lookup, `respValid` is low. `respHit`, `respFault` and `respDirtyUpdate` are only high together with `respValid`.
- R3: On a hit, `respPaddr` equals the stored frame number in bits 31:12 and `lookupVaddr[11:0]` in bits 11:0. The set index is `lookupVaddr[14:12]` and the tag is `lookupVaddr[31:15]`.
- R4: Four distinct pages that map to the same set can be resident together, and all of them hit.
- R5: A fill of a page that is not resident goes to the lowest-numbered invalid way of its set. If all four ways are valid, the victim comes from a 3-bit tree per set {b2,b1,b0}, all zero at reset and after a flush. The victim is way {1,b2} when b0=1, else way {0,b1}. A lookup hit or a fill of way w sets b0 to the inverse of w[1]. It also sets b1 (for w[1]=0) or b2 (for w[1]=1) to the inverse of w[0].
- R6: A fill of a page that is already resident overwrites that entry, so a page never sits in two ways.
- R7: A hit faults when the entry is not present, when a user access meets a supervisor-only page, or when a user write meets a read-only page. A supervisor write to a read-only page does not fault.
- R8: A non-faulting write hit on an entry whose dirty bit is clear raises `respDirtyUpdate` and marks the entry dirty. A later write to the same page does not raise it.
- R9: `flush` invalidates every entry at the clock edge. A lookup in the flush cycle reports a miss.
- R10: A fill presented in the same cycle as `flush` is discarded.
- R11: A faulting access still reports `respHit` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVaddr | input | 32 | Virtual address to translate |
| lookupWrite | input | 1 | Lookup is a write |
| lookupUser | input | 1 | Lookup comes from user level |
| flush | input | 1 | Invalidate all entries (page-directory base written) |
| fillValid | input | 1 | Install a translation this cycle |
| fillVpn | input | 20 | Virtual page number to install |
| fillPfn | input | 20 | Physical frame number to install |
| fillWritable | input | 1 | Page is writable |
| fillUser | input | 1 | Page is accessible from user level |
| fillPresent | input | 1 | Page is present |
| fillDirty | input | 1 | Page-table entry already dirty |
| respValid | output | 1 | Response for the previous cycle's lookup |
| respHit | output | 1 | Translation found |
| respPaddr | output | 32 | Translated physical address (zero on miss) |
| respFault | output | 1 | Permission or not-present fault on a hit |
| respDirtyUpdate | output | 1 | First write to a clean page: page-table dirty bit must be set |

## Verification
The bench drives a fifth page into a full set after a chosen touch order and checks which page is gone. A design with a wrong tree update or victim decode evicts a page that was used recently, and that page then misses. It refills a resident page with a new frame and expects the new frame while the neighbours still hit. A design that stores a duplicate would return the stale frame or raise two hits. It writes twice to a clean supervisor page, checks user access to a supervisor page, a user write to a read-only page, and a hit on a non-present page, and expects the dirty request exactly once. Flush is combined in the same cycle with a lookup and with a fill. A design that let the fill through, or answered the lookup from pre-flush state, would report a hit afterwards. Thousands of seeded random fills, lookups and flushes over a small page pool are compared against a reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // The replacement tree is built for four ways per set.
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic             lookValid;
    logic             lookHit;
    logic             lookFault;
    logic             lookDirty;
    logic [WAY_W-1:0] hitWay;
    logic             doFill;
    logic [WAY_W-1:0] fillWay;
    logic             doFlush;
  } tlbStrobes_t;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [VA_W-1:0]           lookupVaddr,
  input  logic [VA_W-PAGE_BITS-1:0] fillVpn,
  input  logic [PA_W-PAGE_BITS-1:0] fillPfn,
  input  logic                      fillWritable,
  input  logic                      fillUser,
  input  logic                      fillPresent,
  input  logic                      fillDirty,
  input  tlbStrobes_t               st,
  output logic [WAYS-1:0]           hitVec,
  output logic [WAYS-1:0]           fillMatch,
  output logic [WAYS-1:0]           fillSetValid,
  output logic                      selWritable,
  output logic                      selUser,
  output logic                      selPresent,
  output logic                      selDirty,
  output logic                      respValid,
  output logic                      respHit,
  output logic                      respFault,
  output logic                      respDirtyUpdate,
  output logic [PA_W-1:0]           respPaddr
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [PFN_W-1:0] pfn;
    logic             writable;
    logic             user;
    logic             present;
    logic             dirty;
  } entry_t;

  entry_t                       mem [SETS][WAYS];
  logic [SETS-1:0][WAYS-1:0]    validQ;

  logic [VPN_W-1:0] lookVpn;
  logic [IDX_W-1:0] lookIdx, fillIdx;
  logic [TAG_W-1:0] lookTag, fillTag;
  entry_t           selEntry;

  assign lookVpn = lookupVaddr[VA_W-1:PAGE_BITS];
  assign lookIdx = lookVpn[IDX_W-1:0];
  assign lookTag = lookVpn[VPN_W-1:IDX_W];
  assign fillIdx = fillVpn[IDX_W-1:0];
  assign fillTag = fillVpn[VPN_W-1:IDX_W];

  assign fillSetValid = validQ[fillIdx];

  // Tag comparators, one pair per way
  for (genvar g = 0; g < WAYS; g++) begin : gWay
    assign hitVec[g]    = validQ[lookIdx][g] && (mem[lookIdx][g].tag == lookTag);
    assign fillMatch[g] = validQ[fillIdx][g] && (mem[fillIdx][g].tag == fillTag);
  end

  // One-hot select of the hitting entry
  always_comb begin
    selEntry = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) selEntry = selEntry | mem[lookIdx][w];
    end
  end

  assign selWritable = selEntry.writable;
  assign selUser     = selEntry.user;
  assign selPresent  = selEntry.present;
  assign selDirty    = selEntry.dirty;

  // Entry payload; a fill to the same slot overrides the dirty mark
  always_ff @(posedge clk) begin
    if (st.lookDirty) mem[lookIdx][st.hitWay].dirty <= 1'b1;
    if (st.doFill) begin
      mem[fillIdx][st.fillWay] <= '{tag: fillTag, pfn: fillPfn, writable: fillWritable,
                                    user: fillUser, present: fillPresent, dirty: fillDirty};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (st.doFlush) begin
      validQ <= '0;
    end else if (st.doFill) begin
      validQ[fillIdx][st.fillWay] <= 1'b1;
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid       <= 1'b0;
      respHit         <= 1'b0;
      respFault       <= 1'b0;
      respDirtyUpdate <= 1'b0;
      respPaddr       <= '0;
    end else begin
      respValid       <= st.lookValid;
      respHit         <= st.lookHit;
      respFault       <= st.lookFault;
      respDirtyUpdate <= st.lookDirty;
      respPaddr       <= st.lookHit ? {selEntry.pfn, lookupVaddr[PAGE_BITS-1:0]} : '0;
    end
  end

  // R6
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(hitVec));
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN) st.doFlush |=> (validQ == '0));
  // R2
  hit_valid_chk: assert property (@(posedge clk) disable iff (!rstN) respHit |-> respValid);
  // R11
  fault_hit_chk: assert property (@(posedge clk) disable iff (!rstN) respFault |-> respHit);
  // R8
  dirty_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    respDirtyUpdate |-> (respHit && !respFault));
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int SETS = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             lookupWrite,
  input  logic             lookupUser,
  input  logic             flush,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] lookIdx,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [WAYS-1:0]  hitVec,
  input  logic [WAYS-1:0]  fillMatch,
  input  logic [WAYS-1:0]  fillSetValid,
  input  logic             selWritable,
  input  logic             selUser,
  input  logic             selPresent,
  input  logic             selDirty,
  output tlbStrobes_t      st
);
  logic [SETS-1:0][2:0] plruQ;

  function automatic logic [WAY_W-1:0] encodeWay(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++) if (v[w]) r = r | WAY_W'(w);
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] firstFree(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (!v[w]) r = WAY_W'(w);
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] treeVictim(input logic [2:0] b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

  function automatic logic [2:0] treeTouch(input logic [2:0] b, input logic [WAY_W-1:0] w);
    logic [2:0] r;
    r = b;
    r[0] = ~w[1];
    if (w[1]) r[2] = ~w[0];
    else      r[1] = ~w[0];
    return r;
  endfunction

  logic hitNow, faultNow;

  assign hitNow   = lookupValid && !flush && (|hitVec);
  assign faultNow = hitNow && (!selPresent || (lookupUser && !selUser) ||
                               (lookupUser && lookupWrite && !selWritable));

  always_comb begin
    st           = '0;
    st.lookValid = lookupValid;
    st.lookHit   = hitNow;
    st.lookFault = faultNow;
    st.lookDirty = hitNow && !faultNow && lookupWrite && !selDirty;
    st.hitWay    = encodeWay(hitVec);
    st.doFlush   = flush;
    st.doFill    = fillValid && !flush;
    if (|fillMatch)          st.fillWay = encodeWay(fillMatch);
    else if (!(&fillSetValid)) st.fillWay = firstFree(fillSetValid);
    else                     st.fillWay = treeVictim(plruQ[fillIdx]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      plruQ <= '0;
    end else begin
      if (st.lookHit) plruQ[lookIdx] <= treeTouch(plruQ[lookIdx], st.hitWay);
      if (st.doFill)  plruQ[fillIdx] <= treeTouch(plruQ[fillIdx], st.fillWay);
    end
  end

  // R5
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.doFill && !(|fillMatch) && !(&fillSetValid)) |-> !fillSetValid[st.fillWay]);
  // R6
  refill_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.doFill && (|fillMatch)) |-> fillMatch[st.fillWay]);
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      lookupValid,
  input  logic [VA_W-1:0]           lookupVaddr,
  input  logic                      lookupWrite,
  input  logic                      lookupUser,
  input  logic                      flush,
  input  logic                      fillValid,
  input  logic [VA_W-PAGE_BITS-1:0] fillVpn,
  input  logic [PA_W-PAGE_BITS-1:0] fillPfn,
  input  logic                      fillWritable,
  input  logic                      fillUser,
  input  logic                      fillPresent,
  input  logic                      fillDirty,
  output logic                      respValid,
  output logic                      respHit,
  output logic [PA_W-1:0]           respPaddr,
  output logic                      respFault,
  output logic                      respDirtyUpdate
);
  localparam int IDX_W = $clog2(SETS);

  tlbStrobes_t     st;
  logic [WAYS-1:0] hitVec, fillMatch, fillSetValid;
  logic            selWritable, selUser, selPresent, selDirty;

  tlb_control #(.SETS(SETS)) uCtrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupWrite(lookupWrite),
    .lookupUser(lookupUser), .flush(flush), .fillValid(fillValid),
    .lookIdx(lookupVaddr[PAGE_BITS +: IDX_W]), .fillIdx(fillVpn[IDX_W-1:0]),
    .hitVec(hitVec), .fillMatch(fillMatch), .fillSetValid(fillSetValid),
    .selWritable(selWritable), .selUser(selUser), .selPresent(selPresent),
    .selDirty(selDirty), .st(st)
  );

  tlb_datapath #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .SETS(SETS)) uData (
    .clk(clk), .rstN(rstN), .lookupVaddr(lookupVaddr), .fillVpn(fillVpn), .fillPfn(fillPfn),
    .fillWritable(fillWritable), .fillUser(fillUser), .fillPresent(fillPresent),
    .fillDirty(fillDirty), .st(st), .hitVec(hitVec), .fillMatch(fillMatch),
    .fillSetValid(fillSetValid), .selWritable(selWritable), .selUser(selUser),
    .selPresent(selPresent), .selDirty(selDirty), .respValid(respValid), .respHit(respHit),
    .respFault(respFault), .respDirtyUpdate(respDirtyUpdate), .respPaddr(respPaddr)
  );
endmodule

// File: tb/tlb_top_test.sv
`timescale 1ns/1ps
module tlb_top_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, lookupValid, lookupWrite, lookupUser, flush, fillValid;
  logic [31:0] lookupVaddr;
  logic [19:0] fillVpn, fillPfn;
  logic        fillWritable, fillUser, fillPresent, fillDirty;
  logic        respValid, respHit, respFault, respDirtyUpdate;
  logic [31:0] respPaddr;

  tlb_top uut (.*);

  // Reference model: index = set*4 + way
  bit        mV [32];
  bit [19:0] mVpn [32];
  bit [19:0] mPfn [32];
  bit        mW [32], mU [32], mP [32], mD [32];
  bit [2:0]  mPl [8];

  int  checks = 0, errors = 0;
  bit  done = 0;
  bit  lastHit, lastFault, lastDirty;
  bit [31:0] lastPa;

  function automatic int findWay(bit [19:0] vpn);
    for (int w = 0; w < 4; w++)
      if (mV[vpn[2:0]*4 + w] && mVpn[vpn[2:0]*4 + w] == vpn) return w;
    return -1;
  endfunction

  function automatic int victimOf(bit [2:0] b);
    return b[0] ? (b[2] ? 3 : 2) : (b[1] ? 1 : 0);
  endfunction

  function automatic bit [2:0] touchOf(bit [2:0] b, int w);
    bit [2:0] r = b;
    r[0] = (w < 2);
    if (w >= 2) r[2] = (w == 2); else r[1] = (w == 0);
    return r;
  endfunction

  task automatic check(string tag, bit ok, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic step(bit lk, bit [31:0] va, bit wr, bit us, bit fl, bit fi,
                      bit [19:0] fv, bit [19:0] fp, bit fw, bit fu, bit fpr, bit fd, string tag);
    bit eHit = 0, eFault = 0, eDirty = 0;
    bit [31:0] ePa = 0;
    int i, s, j;
    lookupValid = lk; lookupVaddr = va; lookupWrite = wr; lookupUser = us;
    flush = fl; fillValid = fi; fillVpn = fv; fillPfn = fp;
    fillWritable = fw; fillUser = fu; fillPresent = fpr; fillDirty = fd;
    if (lk && !fl) begin
      i = findWay(va[31:12]);
      if (i >= 0) begin
        s = va[14:12];
        eHit = 1; ePa = {mPfn[s*4+i], va[11:0]};
        eFault = !mP[s*4+i] || (us && !mU[s*4+i]) || (us && wr && !mW[s*4+i]);
        eDirty = !eFault && wr && !mD[s*4+i];
        if (eDirty) mD[s*4+i] = 1;
        mPl[s] = touchOf(mPl[s], i);
      end
    end
    if (fi && !fl) begin
      s = fv[2:0];
      j = findWay(fv);
      if (j < 0) begin
        for (int w = 3; w >= 0; w--) if (!mV[s*4+w]) j = w;
      end
      if (j < 0) j = victimOf(mPl[s]);
      mV[s*4+j] = 1; mVpn[s*4+j] = fv; mPfn[s*4+j] = fp;
      mW[s*4+j] = fw; mU[s*4+j] = fu; mP[s*4+j] = fpr; mD[s*4+j] = fd;
      mPl[s] = touchOf(mPl[s], j);
    end
    if (fl) begin
      for (int k = 0; k < 32; k++) mV[k] = 0;
      for (int k = 0; k < 8; k++) mPl[k] = 0;
    end
    @(negedge clk);
    lastHit = respHit; lastFault = respFault; lastDirty = respDirtyUpdate; lastPa = respPaddr;
    if (lk) begin
      check(tag, respValid && respHit == eHit && respFault == eFault &&
                 respDirtyUpdate == eDirty && (!eHit || respPaddr == ePa),
            $sformatf("va=%h act v%0b h%0b f%0b d%0b pa=%h exp v1 h%0b f%0b d%0b pa=%h",
                      va, respValid, respHit, respFault, respDirtyUpdate, respPaddr,
                      eHit, eFault, eDirty, ePa));
    end else begin
      check(tag, !respValid && !respHit,
            $sformatf("idle act v%0b h%0b exp v0 h0", respValid, respHit));
    end
    lookupValid = 0; flush = 0; fillValid = 0;
  endtask

  task automatic look(bit [31:0] va, bit wr, bit us, string tag);
    step(1, va, wr, us, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(bit [19:0] v, bit [19:0] p, bit w, bit u, bit pr, bit d, string tag);
    step(0, 0, 0, 0, 0, 1, v, p, w, u, pr, d, tag);
  endtask

  task automatic expectBit(string tag, bit act, bit exp);
    check(tag, act == exp, $sformatf("act %0b exp %0b", act, exp));
  endtask

  localparam bit [19:0] PA_ = 20'h00012, PB = 20'h0001A, PC = 20'h00022,
                        PD = 20'h0002A, PE = 20'h00032, PF = 20'h00040,
                        PG = 20'h00048, PH = 20'h00050;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    rstN = 0; lookupValid = 0; lookupVaddr = 0; lookupWrite = 0; lookupUser = 0;
    flush = 0; fillValid = 0; fillVpn = 0; fillPfn = 0;
    fillWritable = 0; fillUser = 0; fillPresent = 0; fillDirty = 0;
    repeat (3) @(negedge clk);
    check("R1", !respValid && !respHit, "reset outputs act high exp low");
    rstN = 1;

    // R1: empty buffer misses
    look(32'h0000_2000, 0, 0, "R1");
    expectBit("R1 miss", lastHit, 0);
    // R2: no lookup, no response
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");

    // R4: four pages in set 2
    fill(PA_, 20'h00100, 1, 1, 1, 0, "R4");
    fill(PB, 20'h00101, 1, 1, 1, 0, "R4");
    fill(PC, 20'h00102, 1, 1, 1, 0, "R4");
    fill(PD, 20'h00103, 1, 1, 1, 0, "R4");
    look({PA_, 12'h010}, 0, 1, "R4 R3"); expectBit("R4 A", lastHit, 1);
    check("R3", lastPa == 32'h0010_0010, $sformatf("act %h exp 00100010", lastPa));
    look({PB, 12'h020}, 0, 1, "R4"); expectBit("R4 B", lastHit, 1);
    look({PC, 12'h030}, 0, 1, "R4"); expectBit("R4 C", lastHit, 1);
    look({PD, 12'h040}, 0, 1, "R4"); expectBit("R4 D", lastHit, 1);
    look({PA_, 12'h050}, 0, 1, "R5");
    // R5: tree points at way 2, holding C
    fill(PE, 20'h00104, 1, 1, 1, 0, "R5");
    look({PC, 12'h0}, 0, 1, "R5"); expectBit("R5 evicted C", lastHit, 0);
    look({PE, 12'h0}, 0, 1, "R5"); expectBit("R5 new E", lastHit, 1);
    look({PB, 12'h0}, 0, 1, "R5"); expectBit("R5 kept B", lastHit, 1);

    // R6: refill resident page with new frame
    fill(PA_, 20'h001AB, 1, 1, 1, 0, "R6");
    look({PA_, 12'h345}, 0, 1, "R6");
    check("R6", lastPa == 32'h001A_B345, $sformatf("act %h exp 001ab345", lastPa));
    look({PD, 12'h0}, 0, 1, "R6"); expectBit("R6 D kept", lastHit, 1);
    look({PE, 12'h0}, 0, 1, "R6"); expectBit("R6 E kept", lastHit, 1);

    // R7 / R8 / R11
    fill(PF, 20'h00200, 0, 0, 1, 0, "R7");
    look({PF, 12'h0}, 0, 1, "R7"); expectBit("R7 user on supervisor", lastFault, 1);
    expectBit("R11 fault is hit", lastHit, 1);
    look({PF, 12'h0}, 1, 0, "R7"); expectBit("R7 supervisor write ro", lastFault, 0);
    expectBit("R8 first write", lastDirty, 1);
    look({PF, 12'h4}, 1, 0, "R8"); expectBit("R8 second write", lastDirty, 0);
    fill(PG, 20'h00201, 0, 1, 1, 0, "R7");
    look({PG, 12'h0}, 1, 1, "R7"); expectBit("R7 user write ro", lastFault, 1);
    expectBit("R8 no dirty on fault", lastDirty, 0);
    look({PG, 12'h0}, 0, 1, "R7"); expectBit("R7 user read", lastFault, 0);
    fill(PH, 20'h00202, 1, 1, 0, 0, "R7");
    look({PH, 12'h0}, 0, 0, "R11"); expectBit("R11 not present", lastFault, 1);
    expectBit("R11 hit", lastHit, 1);

    // R9: flush with same-cycle lookup
    step(1, {PB, 12'h0}, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    expectBit("R9 flush cycle miss", lastHit, 0);
    look({PB, 12'h0}, 0, 1, "R9"); expectBit("R9 after", lastHit, 0);
    look({PF, 12'h0}, 0, 0, "R9"); expectBit("R9 after F", lastHit, 0);

    // R10: fill in flush cycle dropped
    step(0, 0, 0, 0, 1, 1, PA_, 20'h00300, 1, 1, 1, 1, "R10");
    look({PA_, 12'h0}, 0, 0, "R10"); expectBit("R10 dropped", lastHit, 0);

    // Random mix
    for (int n = 0; n < 5000; n++) begin
      int op;
      bit [19:0] v;
      op = $urandom_range(0, 99);
      v = {14'($urandom_range(0, 5)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7))};
      v = {v[19:3], 3'($urandom_range(0, 7))};
      v[19:3] = 17'($urandom_range(0, 5));
      if (op < 50)
        look({v, 12'($urandom)}, 1'($urandom), 1'($urandom), "R3 R7 R8 random");
      else if (op < 92)
        fill(v, 20'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0),
             1'($urandom), "R5 R6 random");
      else if (op < 94)
        step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R9 random");
      else
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule